// File: doc/BRIEF.md
# Four-Bit ALU with Decimal Seven-Segment Readout

This block is a purely combinational 4-bit arithmetic/logic unit. It takes two unsigned 4-bit operands, a unit-select bit and a 2-bit function code. It returns a 4-bit result, a carry flag and two seven-segment digit patterns that are ready to drive a pair of displays. A single ripple adder serves both addition and subtraction. For subtraction, the second operand is inverted and the carry input is forced high.

The display path formats results differently depending on the unit. Logic results appear as one hexadecimal digit, with the second display dark. Arithmetic results appear in decimal. The second display holds a leading "1" for values of ten or more, or a minus sign when a subtraction goes below zero. In that negative case the first display shows the magnitude. The block has no clock and no handshake, so every output follows the inputs within the same cycle. Any registering or display scanning belongs to the surrounding logic.

Top module: `alu4_dec_disp`

## Requirements
- R1: With `arith_mode`=0, `op_sel` 00 gives `result` = A AND B, 01 gives A OR B, and 10 gives A XOR B. `carry_flag` is low.
- R2: With `arith_mode`=0 and `op_sel`=11, `result` = NOT A. Operand B has no effect on any output, and `carry_flag` is low.
- R3: With `arith_mode`=1 and `op_sel`=00, `result` = (A+B) mod 16 and `carry_flag` = carry out of the 4-bit sum, that is, A+B > 15.
- R4: With `arith_mode`=1 and `op_sel`=01, `result` = (A-B) mod 16 and `carry_flag` is low.
- R5: With `arith_mode`=1 and `op_sel` 10 or 11, `result` = 0, `carry_flag` = 0 and both digit outputs are 0 (blank).
- R6: In logic mode, `seg_lo` shows `result` as one hex digit and `seg_hi` is blank.
- R7: For addition, and for subtraction with A >= B, a `result` value v >= 10 gives `seg_hi` = digit 1 and `seg_lo` = digit v-10. A value v < 10 gives `seg_hi` blank and `seg_lo` = digit v.
- R8: For subtraction with A < B (unsigned), `seg_hi` shows a minus sign (7'h40, segment g only) and `seg_lo` shows the magnitude B-A as a hex digit.
- R9: Segment vectors are active-high, with bit 6 = g down to bit 0 = a. Digits 0..F encode as 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71 (hex), and blank is 00.
- R10: All outputs are a combinational function of the present inputs, with no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Operand A, unsigned |
| op_b | input | 4 | Operand B, unsigned |
| arith_mode | input | 1 | 0 selects the logic unit, 1 selects the arithmetic unit |
| op_sel | input | 2 | Function code within the selected unit |
| result | output | 4 | 4-bit result |
| carry_flag | output | 1 | Carry out of an addition |
| seg_lo | output | 7 | Ones digit segments, g..a, active-high |
| seg_hi | output | 7 | Tens or sign digit segments, g..a, active-high |

## Verification
The block holds no state. A fault in the adder chain, the operation decode or the digit formatting is therefore visible at the ports for the very vector that exercises it, in the same cycle. A broken carry link corrupts `result` and `carry_flag` for operand pairs that propagate through that bit. A wrong borrow sense swaps the minus sign and the tens digit for subtractions near A = B. A decode slip lights a display on reserved codes or lets B leak into NOT A. Random vectors plus the corners at 9/10, A = B, 0-15 and 15+15 expose each of these immediately.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ADD, OP_SUB, OP_RSV
  } alu_op_e;

  typedef enum logic [1:0] {
    DK_BLANK, DK_HEX, DK_MINUS
  } disp_kind_e;

  typedef struct packed {
    disp_kind_e  kind;
    logic [3:0]  val;
  } disp_dig_t;

  function automatic alu_op_e decode_op(input logic mode, input logic [1:0] sel);
    alu_op_e o;
    if (!mode) begin
      case (sel)
        2'b00:   o = OP_AND;
        2'b01:   o = OP_OR;
        2'b10:   o = OP_XOR;
        default: o = OP_NOT;
      endcase
    end else begin
      case (sel)
        2'b00:   o = OP_ADD;
        2'b01:   o = OP_SUB;
        default: o = OP_RSV;
      endcase
    end
    return o;
  endfunction

  function automatic logic is_logic_op(input alu_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) || (o == OP_NOT);
  endfunction

endpackage

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         carry,
  output logic         neg
);
  logic         sub;
  logic [W-1:0] bx;
  logic [W-1:0] s;
  logic [W:0]   c;

  assign sub  = (op == OP_SUB);
  assign bx   = b ^ {W{sub}};
  assign c[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = a[i] ^ bx[i] ^ c[i];
    assign c[i+1] = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
  end

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      OP_ADD:  y = s;
      OP_SUB:  y = s;
      default: y = '0;
    endcase
  end

  assign carry = (op == OP_ADD) & c[W];
  assign neg   = sub & ~c[W];

  // R3: ripple chain matches a wide addition
  always_comb begin
    if (op == OP_ADD)
      a_r3_add_sum: assert ({carry, y} == ({1'b0, a} + {1'b0, b}));
  end

  // R8: borrow from the chain agrees with an unsigned compare
  always_comb begin
    if (op == OP_SUB)
      a_r8_borrow_cmp: assert (neg == (a < b));
  end

  // R4: subtraction never raises the carry flag
  always_comb begin
    if (op != OP_ADD)
      a_r4_no_overflow: assert (!carry);
  end
endmodule

// File: rtl/alu4_fmt.sv
module alu4_fmt
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  alu_op_e      op,
  input  logic [W-1:0] y,
  input  logic         neg,
  output disp_dig_t    hi,
  output disp_dig_t    lo
);
  localparam logic [W-1:0] TEN = W'(10);

  logic [W-1:0] mag;
  assign mag = -y;

  always_comb begin
    hi = '{kind: DK_BLANK, val: 4'd0};
    lo = '{kind: DK_BLANK, val: 4'd0};
    if (is_logic_op(op)) begin
      lo = '{kind: DK_HEX, val: 4'(y)};
    end else if (op == OP_ADD || op == OP_SUB) begin
      if (neg) begin
        hi = '{kind: DK_MINUS, val: 4'd0};
        lo = '{kind: DK_HEX, val: 4'(mag)};
      end else if (y >= TEN) begin
        hi = '{kind: DK_HEX, val: 4'd1};
        lo = '{kind: DK_HEX, val: 4'(y - TEN)};
      end else begin
        lo = '{kind: DK_HEX, val: 4'(y)};
      end
    end
  end

  // R7: non-negative arithmetic keeps the ones digit decimal
  always_comb begin
    if ((op == OP_ADD || op == OP_SUB) && !neg)
      a_r7_decimal_ones: assert (lo.val < 4'd10);
  end

  // R8: negative results show a sign and a magnitude that cancels y
  always_comb begin
    if (neg)
      a_r8_minus_mag: assert (hi.kind == DK_MINUS && W'(lo.val + 4'(y)) == '0);
  end

  // R6: logic results never light the second display
  always_comb begin
    if (is_logic_op(op))
      a_r6_hi_dark: assert (hi.kind == DK_BLANK);
  end
endmodule

// File: rtl/alu4_seg.sv
module alu4_seg
  import alu4_pkg::*;
(
  input  disp_dig_t  d,
  output logic [6:0] seg
);
  logic [6:0] hexpat;

  always_comb begin
    case (d.val)
      4'h0: hexpat = 7'h3F;
      4'h1: hexpat = 7'h06;
      4'h2: hexpat = 7'h5B;
      4'h3: hexpat = 7'h4F;
      4'h4: hexpat = 7'h66;
      4'h5: hexpat = 7'h6D;
      4'h6: hexpat = 7'h7D;
      4'h7: hexpat = 7'h07;
      4'h8: hexpat = 7'h7F;
      4'h9: hexpat = 7'h6F;
      4'hA: hexpat = 7'h77;
      4'hB: hexpat = 7'h7C;
      4'hC: hexpat = 7'h39;
      4'hD: hexpat = 7'h5E;
      4'hE: hexpat = 7'h79;
      default: hexpat = 7'h71;
    endcase
  end

  always_comb begin
    case (d.kind)
      DK_HEX:   seg = hexpat;
      DK_MINUS: seg = 7'b1000000;
      default:  seg = 7'b0000000;
    endcase
  end

  // R9: a minus lights exactly one segment, a digit lights at least two
  always_comb begin
    if (d.kind == DK_MINUS)
      a_r9_minus_single: assert ($countones(seg) == 1 && seg[6]);
    if (d.kind == DK_HEX)
      a_r9_digit_lit: assert ($countones(seg) >= 2);
  end
endmodule

// File: rtl/alu4_dec_disp.sv
module alu4_dec_disp
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         arith_mode,
  input  logic [1:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_flag,
  output logic [6:0]   seg_lo,
  output logic [6:0]   seg_hi
);
  alu_op_e   op;
  logic      neg;
  disp_dig_t dig_hi;
  disp_dig_t dig_lo;

  assign op = decode_op(arith_mode, op_sel);

  alu4_core #(.W(W)) u_core (
    .a(op_a), .b(op_b), .op(op), .y(result), .carry(carry_flag), .neg(neg)
  );

  alu4_fmt #(.W(W)) u_fmt (
    .op(op), .y(result), .neg(neg), .hi(dig_hi), .lo(dig_lo)
  );

  alu4_seg u_seg_lo (.d(dig_lo), .seg(seg_lo));
  alu4_seg u_seg_hi (.d(dig_hi), .seg(seg_hi));

  // R5: reserved arithmetic codes leave every output quiet
  always_comb begin
    if (arith_mode && op_sel[1])
      a_r5_reserved_quiet: assert (result == '0 && !carry_flag && seg_lo == '0 && seg_hi == '0);
  end
endmodule

// File: tb/alu4_dec_disp_tb.sv
module alu4_dec_disp_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] op_a, op_b, result;
  logic       arith_mode, carry_flag;
  logic [1:0] op_sel;
  logic [6:0] seg_lo, seg_hi;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  alu4_dec_disp u_dut (
    .op_a(op_a), .op_b(op_b), .arith_mode(arith_mode), .op_sel(op_sel),
    .result(result), .carry_flag(carry_flag), .seg_lo(seg_lo), .seg_hi(seg_hi)
  );

  function automatic logic [6:0] hexseg(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [3:0] exp_y(input logic m, input logic [1:0] s, input logic [3:0] a, input logic [3:0] b);
    if (!m) begin
      case (s)
        2'd0: return a & b;
        2'd1: return a | b;
        2'd2: return a ^ b;
        default: return ~a;
      endcase
    end
    if (s == 2'd0) return 4'(a + b);
    if (s == 2'd1) return 4'(a - b);
    return 4'd0;
  endfunction

  function automatic logic exp_c(input logic m, input logic [1:0] s, input logic [3:0] a, input logic [3:0] b);
    return m && s == 2'd0 && (int'(a) + int'(b) > 15);
  endfunction

  // returns {hi, lo}
  function automatic logic [13:0] exp_seg(input logic m, input logic [1:0] s, input logic [3:0] a, input logic [3:0] b);
    logic [3:0] v;
    v = exp_y(m, s, a, b);
    if (!m) return {7'h00, hexseg(v)};
    if (s[1]) return 14'h0;
    if (s == 2'd1 && a < b) return {7'h40, hexseg(4'(b - a))};
    if (v >= 10) return {hexseg(4'd1), hexseg(4'(v - 10))};
    return {7'h00, hexseg(v)};
  endfunction

  function automatic string tag_y(input logic m, input logic [1:0] s);
    if (!m) return (s == 2'd3) ? "R2" : "R1";
    if (s == 2'd0) return "R3";
    if (s == 2'd1) return "R4";
    return "R5";
  endfunction

  function automatic string tag_d(input logic m, input logic [1:0] s, input logic [3:0] a, input logic [3:0] b);
    if (!m) return "R6";
    if (s[1]) return "R5";
    if (s == 2'd1 && a < b) return "R8";
    return "R7";
  endfunction

  task automatic chk(input string req, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (m=%0d s=%0d a=%0d b=%0d)",
               req, act, exp_v, arith_mode, op_sel, op_a, op_b);
    end
  endtask

  task automatic apply(input logic m, input logic [1:0] s, input logic [3:0] a, input logic [3:0] b);
    logic [13:0] sg;
    @(posedge clk);
    #1;
    arith_mode = m; op_sel = s; op_a = a; op_b = b;
    @(negedge clk);
    sg = exp_seg(m, s, a, b);
    chk(tag_y(m, s), result, exp_y(m, s, a, b));
    chk(m ? "R3" : "R1", carry_flag, exp_c(m, s, a, b));
    chk({tag_d(m, s, a, b), "/R9 lo"}, seg_lo, sg[6:0]);
    chk({tag_d(m, s, a, b), "/R9 hi"}, seg_hi, sg[13:7]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5A17;
    arith_mode = 0; op_sel = 0; op_a = 0; op_b = 0;
    @(negedge clk);
    // R10: all-zero inputs give the settled idle outputs
    chk("R10", result, 0);
    chk("R10", seg_lo, 7'h3F);
    chk("R10", seg_hi, 0);
    // directed corners
    apply(1, 2'd0, 4'd4, 4'd5);    // R7: 9, single digit
    apply(1, 2'd0, 4'd4, 4'd6);    // R7: 10
    apply(1, 2'd0, 4'd15, 4'd15);  // R3: carry
    apply(1, 2'd0, 4'd8, 4'd8);    // R3: exactly 16
    apply(1, 2'd1, 4'd7, 4'd7);    // R4: zero
    apply(1, 2'd1, 4'd0, 4'd15);   // R8: -15
    apply(1, 2'd1, 4'd15, 4'd0);   // R7: 15
    apply(1, 2'd1, 4'd3, 4'd4);    // R8: -1
    apply(1, 2'd2, 4'd9, 4'd9);    // R5
    apply(1, 2'd3, 4'd15, 4'd15);  // R5
    apply(0, 2'd3, 4'd5, 4'd0);    // R2
    apply(0, 2'd3, 4'd5, 4'd15);   // R2: B has no effect
    for (int i = 0; i < 16; i++) apply(0, 2'd2, 4'(i), 4'd0); // R6/R9: every hex digit
    void'($urandom(seed));
    for (int k = 0; k < 600; k++) begin
      logic [6:0] r;
      r = 7'($urandom);
      apply(r[0], 2'($urandom), 4'($urandom), 4'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule